// File: doc/BRIEF.md
# Interleaved Line Refill Reader

This block fetches one cache line of eight words from a main memory built out of four independent memory modules. Words are spread across the modules by their lowest address bits, so word addresses that follow one another fall into modules that follow one another. Each module has its own address buffer register and its own data buffer register. All four modules can therefore run their slow accesses at the same time while a single data bus carries the results back.

A requester presents a base word address with a valid strobe. The block accepts the request only when it is idle. It broadcasts the address in one cycle and starts every module. It then returns the eight words in ascending address order, one per cycle, as soon as each one is ready, and flags the eighth word as the last. The module models are cycle-accurate behavioural stand-ins. The first access in a module takes a fixed number of cycles, and each later access in the same row takes a shorter fixed number. Each model returns the bitwise inverse of the word address as that word's contents, so no storage is needed.

A build parameter replaces the four modules with a single non-interleaved module. This lets the two refill costs be compared: 15 cycles with interleaving against 36 cycles without.

Top module: `ilv_line_reader`

## Requirements
- R1: While rst_n is low at a rising clock edge, the block returns to idle: after that edge req_ready is 1 and rsp_valid and rsp_last are 0, even if a line was in progress.
- R2: A request is taken at a rising edge where req_valid and req_ready are both 1. req_ready is 0 from the edge after acceptance until the line has been fully delivered.
- R3: Word k (k = 0..7) of a line with base address B carries the data value ~(B + k), with the address wrapping modulo 2^16. The eight words are delivered in ascending k order.
- R4: In interleaved mode, counting the accepting edge as edge 0, word k is valid in the cycle after edge 7 + k. The eight words therefore form an unbroken burst, and req_ready returns to 1 after edge 15.
- R5: In non-interleaved mode, word k is valid only in the cycle after edge 7 + 4k, and req_ready returns to 1 after edge 36.
- R6: rsp_last is 1 exactly when the eighth word (k = 7) is valid, and 0 in every other cycle.
- R7: The module is chosen by address bits [1:0]. A base address that is not a multiple of four, including one that wraps past 16'hFFFF, keeps the timing of R4 and the data of R3.
- R8: req_valid asserted while the block is busy, with any address, is ignored: the words of the line in progress are unchanged, and no extra line starts once req_ready returns if req_valid has dropped by then.
- R9: A request held on req_valid while busy is accepted at the first edge after req_ready returns to 1, and that line then follows R3 and R4 from its own accepting edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Line request strobe |
| req_addr | input | 16 | Base word address of the line |
| req_ready | output | 1 | High when idle and able to accept a request |
| rsp_valid | output | 1 | A line word is on rsp_data this cycle |
| rsp_data | output | 16 | Returned word |
| rsp_last | output | 1 | Marks the eighth word of the line |

## Verification
All timing is counted from the rising edge that accepts a request. In interleaved mode word k is due just after edge 7 + k and req_ready comes back after edge 15. Without interleaving, word k is due after edge 7 + 4k and req_ready comes back after edge 36. The bench drives and samples on falling edges and keeps its own edge counter from the acceptance. After every edge it checks whether a word must or must not be present, its value and its last flag, and the ready state. A word that comes early, comes late or is missing is therefore caught at the exact cycle it goes wrong. Chained and ignored requests are counted from their own accepting edge in the same way.

// File: rtl/ilv_pkg.sv
// Shared types for the interleaved line refill reader.
// Assumes: nothing beyond IEEE 1800-2017.
package ilv_pkg;

    // Sequencer phases: idle, address broadcast, word transfer.
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_ADDR = 2'd1,
        SEQ_XFER = 2'd2
    } seq_state_t;

endpackage

// File: rtl/ilv_bank_model.sv
// Behavioural memory module with its own address buffer register (abr_q)
// and data buffer register (dbr_q). On start it reads WORDS consecutive
// local words: the first after FIRST_LAT cycles, each next one ROW_LAT
// cycles after the previous. A word's content is the inverse of its global
// word address, rebuilt from the local address and the module index.
// Assumes: FIRST_LAT >= 1, ROW_LAT >= 1, and the reader pops each word
// before the following one lands, or in the same cycle it lands.
module ilv_bank_model #(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 16,
    parameter int IDX_W     = 2,
    parameter int LOC_W     = 14,
    parameter int BANK_IDX  = 0,
    parameter int WORDS     = 2,
    parameter int FIRST_LAT = 6,
    parameter int ROW_LAT   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LOC_W-1:0]  start_loc,
    input  logic              pop,
    output logic              dbr_full,
    output logic [DATA_W-1:0] dbr_data
);

    localparam int LAT_MAX = (FIRST_LAT > ROW_LAT) ? FIRST_LAT : ROW_LAT;
    localparam int CNT_W   = $clog2(LAT_MAX + 1);
    localparam int LEFT_W  = $clog2(WORDS + 1);

    logic [LOC_W-1:0]  abr_q;
    logic [CNT_W-1:0]  lat_cnt_q;
    logic [LEFT_W-1:0] left_q;
    logic              busy_q;
    logic              load_now;
    logic [ADDR_W-1:0] glob_addr;
    logic [DATA_W-1:0] dbr_q;
    logic              full_q;

    // Rebuild the global word address from the local one and the module index.
    generate
        if (IDX_W == 0) begin : g_flat_addr
            assign glob_addr = abr_q;
        end else begin : g_ilv_addr
            assign glob_addr = {abr_q, IDX_W'(BANK_IDX)};
        end
    endgenerate

    // A word is ready when the access countdown reaches zero.
    assign load_now = busy_q && (lat_cnt_q == '0);

    // Access sequencing: load the address buffer, count latency, step the address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            abr_q     <= '0;
            lat_cnt_q <= '0;
            left_q    <= '0;
            busy_q    <= 1'b0;
        end else if (start) begin
            abr_q     <= start_loc;
            lat_cnt_q <= CNT_W'(FIRST_LAT - 1);
            left_q    <= LEFT_W'(WORDS);
            busy_q    <= 1'b1;
        end else if (load_now) begin
            abr_q  <= abr_q + 1'b1;
            left_q <= left_q - 1'b1;
            if (left_q == LEFT_W'(1)) begin
                busy_q <= 1'b0;
            end else begin
                lat_cnt_q <= CNT_W'(ROW_LAT - 1);
            end
        end else if (busy_q) begin
            lat_cnt_q <= lat_cnt_q - 1'b1;
        end
    end

    // Data buffer: filled on a completed access, emptied when the reader pops it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dbr_q  <= '0;
            full_q <= 1'b0;
        end else if (load_now) begin
            dbr_q  <= DATA_W'(~glob_addr);
            full_q <= 1'b1;
        end else if (pop || start) begin
            full_q <= 1'b0;
        end
    end

    assign dbr_full = full_q;
    assign dbr_data = dbr_q;

    // A new word must never land on a word the reader has not taken yet.
    assert_dbr_no_overrun_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_now && full_q) |-> pop)
        else $error("data buffer overrun in module %0d", BANK_IDX);

    // The reader only pops a buffer that holds a word.
    assert_pop_needs_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> full_q)
        else $error("pop from empty data buffer in module %0d", BANK_IDX);

endmodule

// File: rtl/ilv_addr_split.sv
// Works out, for every interleaved module, the local address of the first
// line word that falls into it. Module m gets the word at offset
// (m - base[IDX_W-1:0]) mod NUM_MODS from the base, and its local address
// is that word address with the module-select bits removed.
// Assumes: NUM_MODS is a power of two and IDX_W = log2(NUM_MODS) >= 1.
module ilv_addr_split #(
    parameter int ADDR_W   = 16,
    parameter int NUM_MODS = 4,
    parameter int IDX_W    = 2,
    parameter int LOC_W    = 14
) (
    input  logic [ADDR_W-1:0]                 base,
    output logic [NUM_MODS-1:0][LOC_W-1:0]    start_loc
);

    generate
        for (genvar m = 0; m < NUM_MODS; m++) begin : g_mod
            logic [IDX_W-1:0]  offset;
            logic [ADDR_W-1:0] first_addr;
            // Distance from the base to this module's first word, then its local address.
            always_comb begin
                offset       = IDX_W'(m) - base[IDX_W-1:0];
                first_addr   = base + ADDR_W'(offset);
                start_loc[m] = first_addr[ADDR_W-1:IDX_W];
            end
        end
    endgenerate

endmodule

// File: rtl/ilv_seq_ctrl.sv
// Request sequencer and output bus steering. Accepts a line request only
// when idle, spends one cycle broadcasting the address (start pulse to all
// modules), then walks word indices 0..LINE_WORDS-1. It presents word k as
// soon as the module that holds it reports a full data buffer, and pops
// that buffer in the same cycle.
// Assumes: module for word k is (base + k) mod NUM_BANKS.
module ilv_seq_ctrl
    import ilv_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 16,
    parameter int LINE_WORDS = 8,
    parameter int NUM_BANKS  = 4,
    parameter int SEL_W      = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              req_valid,
    input  logic [ADDR_W-1:0]                 req_addr,
    output logic                              req_ready,
    output logic [ADDR_W-1:0]                 base_q,
    output logic                              start,
    input  logic [NUM_BANKS-1:0]              bank_full,
    input  logic [NUM_BANKS-1:0][DATA_W-1:0]  bank_data,
    output logic [NUM_BANKS-1:0]              bank_pop,
    output logic                              rsp_valid,
    output logic [DATA_W-1:0]                 rsp_data,
    output logic                              rsp_last
);

    localparam int IDX_CW = $clog2(LINE_WORDS);

    seq_state_t        state_q;
    logic [IDX_CW-1:0] idx_q;
    logic [SEL_W-1:0]  sel;
    logic              at_end;

    // Module currently owing the next word.
    generate
        if (NUM_BANKS == 1) begin : g_one_bank
            assign sel = '0;
        end else begin : g_many_banks
            assign sel = SEL_W'(base_q) + SEL_W'(idx_q);
        end
    endgenerate

    assign req_ready = (state_q == SEQ_IDLE);
    assign start     = (state_q == SEQ_ADDR);
    assign rsp_valid = (state_q == SEQ_XFER) && bank_full[sel];
    assign rsp_data  = bank_data[sel];
    assign at_end    = (idx_q == IDX_CW'(LINE_WORDS - 1));
    assign rsp_last  = rsp_valid && at_end;

    // Pop the selected module's buffer whenever its word goes out.
    always_comb begin
        bank_pop = '0;
        if (rsp_valid) begin
            bank_pop[sel] = 1'b1;
        end
    end

    // Phase sequencing and word index tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            idx_q   <= '0;
            base_q  <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (req_valid) begin
                        base_q  <= req_addr;
                        idx_q   <= '0;
                        state_q <= SEQ_ADDR;
                    end
                end
                SEQ_ADDR: begin
                    state_q <= SEQ_XFER;
                end
                SEQ_XFER: begin
                    if (rsp_valid) begin
                        idx_q <= idx_q + 1'b1;
                        if (at_end) begin
                            state_q <= SEQ_IDLE;
                        end
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    // A word on the bus means the block is busy and not accepting.
    assert_no_ready_in_burst_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready)
        else $error("ready asserted while delivering a word");

    // An accepted request drops ready on the next cycle.
    assert_accept_drops_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready)
        else $error("ready stayed high after acceptance");

    // Nothing follows the last word of a line.
    assert_nothing_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_last |=> (!rsp_valid && req_ready))
        else $error("activity after the last word");

endmodule

// File: rtl/ilv_line_reader.sv
// Top of the line refill reader. With INTERLEAVE = 1 it builds NUM_MODS
// module models selected by the low address bits and starts them together.
// With INTERLEAVE = 0 it builds one module that serves the whole line.
// Assumes: NUM_MODS is a power of two and divides LINE_WORDS.
module ilv_line_reader #(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 16,
    parameter int NUM_MODS   = 4,
    parameter int LINE_WORDS = 8,
    parameter int FIRST_LAT  = 6,
    parameter int ROW_LAT    = 4,
    parameter bit INTERLEAVE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_last
);

    localparam int NUM_BANKS = INTERLEAVE ? NUM_MODS : 1;
    localparam int IDX_W     = INTERLEAVE ? $clog2(NUM_MODS) : 0;
    localparam int LOC_W     = ADDR_W - IDX_W;
    localparam int PER_BANK  = LINE_WORDS / NUM_BANKS;
    localparam int SEL_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

    logic [ADDR_W-1:0]                base_q;
    logic                             start;
    logic [NUM_BANKS-1:0]             bank_full;
    logic [NUM_BANKS-1:0][DATA_W-1:0] bank_data;
    logic [NUM_BANKS-1:0]             bank_pop;

    ilv_seq_ctrl #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .LINE_WORDS(LINE_WORDS),
        .NUM_BANKS (NUM_BANKS),
        .SEL_W     (SEL_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_addr (req_addr),
        .req_ready(req_ready),
        .base_q   (base_q),
        .start    (start),
        .bank_full(bank_full),
        .bank_data(bank_data),
        .bank_pop (bank_pop),
        .rsp_valid(rsp_valid),
        .rsp_data (rsp_data),
        .rsp_last (rsp_last)
    );

    generate
        if (INTERLEAVE) begin : g_ilv
            logic [NUM_BANKS-1:0][LOC_W-1:0] start_loc;

            ilv_addr_split #(
                .ADDR_W  (ADDR_W),
                .NUM_MODS(NUM_BANKS),
                .IDX_W   (IDX_W),
                .LOC_W   (LOC_W)
            ) u_split (
                .base     (base_q),
                .start_loc(start_loc)
            );

            for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
                ilv_bank_model #(
                    .ADDR_W   (ADDR_W),
                    .DATA_W   (DATA_W),
                    .IDX_W    (IDX_W),
                    .LOC_W    (LOC_W),
                    .BANK_IDX (b),
                    .WORDS    (PER_BANK),
                    .FIRST_LAT(FIRST_LAT),
                    .ROW_LAT  (ROW_LAT)
                ) u_bank (
                    .clk      (clk),
                    .rst_n    (rst_n),
                    .start    (start),
                    .start_loc(start_loc[b]),
                    .pop      (bank_pop[b]),
                    .dbr_full (bank_full[b]),
                    .dbr_data (bank_data[b])
                );
            end

            // Interleaved burst: each word follows the previous with no gap, data one address up.
            assert_unbroken_burst_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (rsp_valid && !rsp_last) |=> (rsp_valid && (rsp_data == $past(rsp_data) - 1'b1)))
                else $error("interleaved burst broken or out of order");
        end else begin : g_flat
            ilv_bank_model #(
                .ADDR_W   (ADDR_W),
                .DATA_W   (DATA_W),
                .IDX_W    (0),
                .LOC_W    (ADDR_W),
                .BANK_IDX (0),
                .WORDS    (LINE_WORDS),
                .FIRST_LAT(FIRST_LAT),
                .ROW_LAT  (ROW_LAT)
            ) u_bank (
                .clk      (clk),
                .rst_n    (rst_n),
                .start    (start),
                .start_loc(base_q),
                .pop      (bank_pop[0]),
                .dbr_full (bank_full[0]),
                .dbr_data (bank_data[0])
            );

            // Single module: same-row accesses keep words at least two cycles apart.
            assert_flat_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
                rsp_valid |=> !rsp_valid)
                else $error("non-interleaved words too close together");
        end
    endgenerate

endmodule

// File: tb/ilv_line_reader_test.sv
// Self-checking bench: uut is interleaved, uut_flat is the single-module build.
module ilv_line_reader_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rv [2];
    logic [15:0] ra [2];
    logic        rdy [2];
    logic        vld [2];
    logic [15:0] dat [2];
    logic        lst [2];

    int n_chk  = 0;
    int n_fail = 0;
    logic [15:0] got_first;
    logic [15:0] got_last;

    always #2.5 clk = ~clk;

    ilv_line_reader uut (
        .clk(clk), .rst_n(rst_n), .req_valid(rv[0]), .req_addr(ra[0]),
        .req_ready(rdy[0]), .rsp_valid(vld[0]), .rsp_data(dat[0]), .rsp_last(lst[0])
    );

    ilv_line_reader #(.INTERLEAVE(1'b0)) uut_flat (
        .clk(clk), .rst_n(rst_n), .req_valid(rv[1]), .req_addr(ra[1]),
        .req_ready(rdy[1]), .rsp_valid(vld[1]), .rsp_data(dat[1]), .rsp_last(lst[1])
    );

    // Vector table: base address, expected first word, expected eighth word.
    typedef struct packed {
        logic [15:0] base;
        logic [15:0] first;
        logic [15:0] last;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{16'h7A00, 16'h85FF, 16'h85F8},
        '{16'h7A01, 16'h85FE, 16'h85F7},
        '{16'h7A02, 16'h85FD, 16'h85F6},
        '{16'h7A03, 16'h85FC, 16'h85F5},
        '{16'hFFFC, 16'h0003, 16'hFFFC},
        '{16'h0000, 16'hFFFF, 16'hFFF8},
        '{16'hA7B4, 16'h584B, 16'h5844},
        '{16'h1235, 16'hEDCA, 16'hEDC3}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Runs one line on instance md (0 interleaved, 1 flat), counting edges from acceptance.
    // hold: 0 drop request, 1 keep junk request while busy, 2 chain alt as next request.
    task automatic run_line(input int md, input logic [15:0] base, input int hold,
                            input logic [15:0] alt, input bit predriven);
        int total = (md == 0) ? 15 : 36;
        string treq = (md == 0) ? "R4" : "R5";
        if (!predriven) begin
            @(negedge clk);
            rv[md] = 1'b1;
            ra[md] = base;
        end
        @(posedge clk);
        @(negedge clk);
        chk(rdy[md] == 1'b0, "R2", "ready after accept", 32'(rdy[md]), 32'd0);
        if (hold == 1) ra[md] = alt;
        else rv[md] = 1'b0;
        for (int n = 1; n <= total; n++) begin
            bit exp_v;
            int k;
            @(negedge clk);
            if (md == 0) begin
                exp_v = (n >= 7) && (n <= 14);
                k = n - 7;
            end else begin
                exp_v = (n >= 7) && (n <= 35) && (((n - 7) % 4) == 0);
                k = (n - 7) / 4;
            end
            chk(vld[md] == exp_v, treq, $sformatf("valid at edge %0d", n), 32'(vld[md]), 32'(exp_v));
            if (exp_v) begin
                logic [15:0] e;
                e = ~(base + 16'(k));
                chk(dat[md] == e, (hold == 1) ? "R8" : "R3", $sformatf("word %0d data", k), 32'(dat[md]), 32'(e));
                chk(lst[md] == (k == 7), "R6", $sformatf("last on word %0d", k), 32'(lst[md]), 32'(k == 7));
                if (k == 0) got_first = dat[md];
                if (k == 7) got_last = dat[md];
            end else begin
                chk(lst[md] == 1'b0, "R6", $sformatf("last idle at edge %0d", n), 32'(lst[md]), 32'd0);
            end
            chk(rdy[md] == (n == total), treq, $sformatf("ready at edge %0d", n), 32'(rdy[md]), 32'(n == total));
            if (n == total - 1 && hold == 1) rv[md] = 1'b0;
            if (n == total - 1 && hold == 2) begin
                rv[md] = 1'b1;
                ra[md] = alt;
            end
        end
    endtask

    initial begin
        rv[0] = 1'b0; rv[1] = 1'b0; ra[0] = '0; ra[1] = '0;
        got_first = '0; got_last = '0;
        repeat (3) @(negedge clk);
        // R1: reset state of both builds.
        chk(rdy[0] == 1'b1 && vld[0] == 1'b0 && lst[0] == 1'b0, "R1", "interleaved reset state",
            {29'd0, rdy[0], vld[0], lst[0]}, 32'b100);
        chk(rdy[1] == 1'b1 && vld[1] == 1'b0 && lst[1] == 1'b0, "R1", "flat reset state",
            {29'd0, rdy[1], vld[1], lst[1]}, 32'b100);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk on the interleaved build (R3, R4, R6, R7).
        foreach (VEC[i]) begin
            run_line(0, VEC[i].base, 0, 16'h0, 1'b0);
            chk(got_first == VEC[i].first, "R7", "first word from table", 32'(got_first), 32'(VEC[i].first));
            chk(got_last == VEC[i].last, "R7", "eighth word from table", 32'(got_last), 32'(VEC[i].last));
        end

        // R5: non-interleaved timing, aligned and wrapping base.
        run_line(1, 16'h7A00, 0, 16'h0, 1'b0);
        run_line(1, 16'hFFFE, 0, 16'h0, 1'b0);

        // R8: junk request held during the busy window is ignored.
        run_line(0, 16'h4440, 1, 16'h5555, 1'b0);
        repeat (3) begin
            @(negedge clk);
            chk(rdy[0] == 1'b1 && vld[0] == 1'b0, "R8", "no line from ignored request",
                {30'd0, rdy[0], vld[0]}, 32'b10);
        end

        // R9: request waiting at the end of a line starts the next one.
        run_line(0, 16'h2000, 2, 16'h3002, 1'b0);
        run_line(0, 16'h3002, 0, 16'h0, 1'b1);

        // R1: reset in the middle of a line returns to idle, then a clean line follows.
        @(negedge clk);
        rv[0] = 1'b1; ra[0] = 16'h0BB0;
        @(posedge clk);
        @(negedge clk);
        rv[0] = 1'b0;
        repeat (8) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(rdy[0] == 1'b1 && vld[0] == 1'b0 && lst[0] == 1'b0, "R1", "idle after mid-line reset",
            {29'd0, rdy[0], vld[0], lst[0]}, 32'b100);
        rst_n = 1'b1;
        repeat (12) begin
            @(negedge clk);
            chk(vld[0] == 1'b0, "R1", "no stale word after reset", 32'(vld[0]), 32'd0);
        end
        run_line(0, 16'h0BB1, 0, 16'h0, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run is reported as a failure.
    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule